// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller

This block gathers up to eight interrupt request lines from peripherals and presents one interrupt line to a processor. A rising edge on a request line is caught in a pending register. A mask register filters the pending bits, and an in-service register tracks the levels whose handlers are running. Priority is fixed: line 0 ranks highest and line 7 lowest. A pending, unmasked line that ranks above every in-service level raises the interrupt output. This lets a more urgent source preempt a handler that is already running, while equal or lower sources wait for their end-of-interrupt command.

The processor answers with two acknowledge pulses. The first pulse freezes the arbitration result, moves the winner from the pending register into the in-service register and holds the interrupt output low. The second pulse causes a type byte to appear on the vector output in the following cycle. The type byte is made of a programmed base in the upper bits and the winning line index in the lower bits. If the winner withdrew its request before the first pulse, the controller returns a spurious type (base with all index bits set) and marks nothing in service.

Software uses a four-entry register port. Through it, software reads the pending, mask and in-service registers, writes the mask and the vector base, and issues end-of-interrupt commands, either non-specific or naming a level.

Top module: `nic_ctrl`

## Requirements
- R1: After reset the pending, mask and in-service registers and the base are zero, the interrupt output is low and no vector is valid.
- R2: A pending bit sets on the clock edge after its request input rises from low to high. It clears when the input is low at an edge. It is read at register address 0, with bit i standing for line i.
- R3: A pending request whose mask bit is 1 never raises the interrupt output. The mask is read and written at address 1, with bit i masking line i.
- R4: Among eligible pending requests, the lowest line index wins.
- R5: On the first acknowledge pulse, the winner's pending bit clears and its in-service bit sets at that edge. The interrupt output stays low until the second pulse.
- R6: One cycle after the second acknowledge pulse, the vector-valid output is high for one cycle. The vector output is then {base[7:3], winning index[2:0]}.
- R7: The interrupt output is high only for a request of strictly higher priority (lower index) than every set in-service bit. Equal and lower requests stay pending.
- R8: Writing address 2 with bit 7 = 0 is a non-specific end-of-interrupt: it clears the lowest-index set in-service bit.
- R9: Writing address 2 with bit 7 = 1 is a specific end-of-interrupt: it clears the in-service bit selected by bits 2:0.
- R10: An acknowledge sequence that starts with no eligible pending request yields the vector {base[7:3], 3'b111} and leaves the in-service register unchanged.
- R11: The in-service register is read at address 2. The base is written at address 3 from bits 7:3 and reads back with bits 2:0 zero. Writes to address 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Peripheral request lines |
| intr_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | Acknowledge pulse, one cycle high per pulse |
| vec_o | output | VEC_W | Type byte for the acknowledged interrupt |
| vec_vld_o | output | 1 | Type byte valid, one cycle after the second pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for reads and writes |
| reg_wdata_i | input | VEC_W | Register write data |
| reg_rdata_o | output | VEC_W | Register read data, combinational from the address |

## Verification
The embedded properties watch, on every cycle, the rules that involve only local state:
- masked requests never raise the interrupt;
- an output request always ranks above every in-service level;
- the first pulse transfers exactly the winning bit;
- a vector appears only after a second pulse;
- a spurious cycle leaves the in-service set alone;
- each kind of end-of-interrupt clears the right bit.

Some behaviour needs whole scenarios, and only the bench can show it. This covers preemption of a running handler followed by the unwinding EOIs, the exact type byte under a reprogrammed base, and a request withdrawn between the interrupt rising and the first acknowledge. The bench also checks register readback after mixed random traffic.

// File: rtl/nic_pkg.sv
package nic_pkg;
   // Register port address map
   typedef enum logic [1:0] {
      REG_PEND = 2'd0,   // read: pending requests
      REG_MASK = 2'd1,   // read/write: mask
      REG_SVC  = 2'd2,   // read: in-service, write: end-of-interrupt
      REG_BASE = 2'd3    // read/write: vector base
   } reg_sel_e;

   // Acknowledge sequencer phase
   typedef enum logic {
      ACK_IDLE = 1'b0,
      ACK_MID  = 1'b1
   } ack_phase_e;
endpackage

// File: rtl/nic_req_latch.sv
module nic_req_latch #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] irr_o
);
   logic [NUM_SRC-1:0] lvl_q;
   logic [NUM_SRC-1:0] rise;

   assign rise = irq_i & ~lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         irr_o <= '0;
      end else begin
         lvl_q <= irq_i;
         irr_o <= ((irr_o & ~clr_i) | rise) & irq_i;
      end
   end

   AST_PEND_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (irr_o & ~$past(irq_i)) == '0);                       // R2
endmodule

// File: rtl/nic_prio_pick.sv
module nic_prio_pick #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic               found_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic [NUM_SRC-1:0] onehot_o
);
   genvar g;
   generate
      for (g = 0; g < NUM_SRC; g++) begin : g_pick
         if (g == 0) begin : g_top
            assign onehot_o[g] = req_i[g];
         end else begin : g_rest
            assign onehot_o[g] = req_i[g] & ~|req_i[g-1:0];
         end
      end
   endgenerate

   assign found_o = |req_i;

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
      end
   end
endmodule

// File: rtl/nic_service.sv
module nic_service #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic               eoi_ns_i,
   input  logic               eoi_sp_i,
   input  logic [IDX_W-1:0]   eoi_lvl_i,
   output logic [NUM_SRC-1:0] isr_o,
   output logic [NUM_SRC-1:0] allow_o
);
   logic [NUM_SRC-1:0] isr_top;
   logic [NUM_SRC-1:0] eoi_clr;

   genvar g;
   generate
      for (g = 0; g < NUM_SRC; g++) begin : g_lvl
         if (g == 0) begin : g_top
            assign isr_top[g] = isr_o[g];
            assign allow_o[g] = ~isr_o[g];
         end else begin : g_rest
            assign isr_top[g] = isr_o[g] & ~|isr_o[g-1:0];
            assign allow_o[g] = ~|isr_o[g:0];
         end
      end
   endgenerate

   always_comb begin
      if (eoi_sp_i)      eoi_clr = NUM_SRC'(1) << eoi_lvl_i;
      else if (eoi_ns_i) eoi_clr = isr_top;
      else               eoi_clr = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_o <= '0;
      else        isr_o <= (isr_o & ~eoi_clr) | set_i;
   end

   AST_NS_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_ns_i && !eoi_sp_i && set_i == '0 && isr_o != '0)
      |=> $countones(isr_o) == $countones($past(isr_o)) - 1);  // R8
   AST_SP_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_sp_i && set_i == '0) |=> !isr_o[$past(eoi_lvl_i)]); // R9
endmodule

// File: rtl/nic_ctrl.sv
module nic_ctrl
   import nic_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int VEC_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_i,
   output logic               intr_o,
   input  logic               ack_i,
   output logic [VEC_W-1:0]   vec_o,
   output logic               vec_vld_o,
   input  logic               reg_wr_i,
   input  logic [1:0]         reg_addr_i,
   input  logic [VEC_W-1:0]   reg_wdata_i,
   output logic [VEC_W-1:0]   reg_rdata_o
);
   localparam int IDX_W  = $clog2(NUM_SRC);
   localparam int BASE_W = VEC_W - IDX_W;

   generate
      if (NUM_SRC < 2 || NUM_SRC != (1 << IDX_W)) begin : g_bad_src
         $error("NUM_SRC must be a power of two of at least 2");
      end
      if (NUM_SRC > VEC_W) begin : g_bad_vec
         $error("VEC_W must hold one bit per source");
      end
   endgenerate

   reg_sel_e           sel;
   logic               wr_mask, wr_base, wr_svc;
   logic               eoi_ns, eoi_sp;
   logic [NUM_SRC-1:0] irr, isr, allow, imr_q, cand, win1h, grant, at_or_below;
   logic [BASE_W-1:0]  base_q;
   logic               found;
   logic [IDX_W-1:0]   win_idx;
   ack_phase_e         phase_q;
   logic               ack_first, ack_second;
   logic [VEC_W-1:0]   pend_vec_q;

   assign sel     = reg_sel_e'(reg_addr_i);
   assign wr_mask = reg_wr_i && sel == REG_MASK;
   assign wr_base = reg_wr_i && sel == REG_BASE;
   assign wr_svc  = reg_wr_i && sel == REG_SVC;
   assign eoi_sp  = wr_svc &  reg_wdata_i[VEC_W-1];
   assign eoi_ns  = wr_svc & ~reg_wdata_i[VEC_W-1];

   assign ack_first  = ack_i && phase_q == ACK_IDLE;
   assign ack_second = ack_i && phase_q == ACK_MID;
   assign grant      = (ack_first && found) ? win1h : '0;

   nic_req_latch #(.NUM_SRC(NUM_SRC)) u_req (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .clr_i(grant), .irr_o(irr)
   );

   nic_service #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_svc (
      .clk(clk), .rst_n(rst_n), .set_i(grant), .eoi_ns_i(eoi_ns),
      .eoi_sp_i(eoi_sp), .eoi_lvl_i(reg_wdata_i[IDX_W-1:0]),
      .isr_o(isr), .allow_o(allow)
   );

   assign cand = irr & ~imr_q & allow;

   nic_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .req_i(cand), .found_o(found), .idx_o(win_idx), .onehot_o(win1h)
   );

   assign intr_o = found && phase_q == ACK_IDLE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr_q  <= '0;
         base_q <= '0;
      end else begin
         if (wr_mask) imr_q  <= reg_wdata_i[NUM_SRC-1:0];
         if (wr_base) base_q <= reg_wdata_i[VEC_W-1:IDX_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= ACK_IDLE;
         pend_vec_q <= '0;
         vec_o      <= '0;
         vec_vld_o  <= 1'b0;
      end else begin
         vec_vld_o <= 1'b0;
         if (ack_first) begin
            phase_q    <= ACK_MID;
            pend_vec_q <= found ? {base_q, win_idx} : {base_q, {IDX_W{1'b1}}};
         end else if (ack_second) begin
            phase_q   <= ACK_IDLE;
            vec_o     <= pend_vec_q;
            vec_vld_o <= 1'b1;
         end
      end
   end

   always_comb begin
      unique case (sel)
         REG_PEND: reg_rdata_o = VEC_W'(irr);
         REG_MASK: reg_rdata_o = VEC_W'(imr_q);
         REG_SVC:  reg_rdata_o = VEC_W'(isr);
         default:  reg_rdata_o = {base_q, {IDX_W{1'b0}}};
      endcase
   end

   assign at_or_below = win1h | (win1h - NUM_SRC'(1));

   AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ((irr & ~imr_q) == '0) |-> !intr_o);                     // R3
   AST_ACK_MOVES_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_first && found) |=> ((isr & $past(win1h)) != '0) && ((irr & $past(win1h)) == '0)); // R5
   AST_VEC_AFTER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      vec_vld_o |-> $past(ack_second));                        // R6
   AST_NEST_ABOVE_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      intr_o |-> (isr & at_or_below) == '0);                   // R7
   AST_SPUR_KEEPS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_first && !found && !wr_svc) |=> isr == $past(isr)); // R10
endmodule

// File: tb/tb_nic_ctrl.sv
module tb_nic_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] irq_i;
   logic       intr_o, ack_i, vec_vld_o, reg_wr_i;
   logic [7:0] vec_o, reg_wdata_i, reg_rdata_o;
   logic [1:0] reg_addr_i;

   always #(CLK_PERIOD/2) clk = ~clk;

   nic_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .intr_o(intr_o), .ack_i(ack_i),
      .vec_o(vec_o), .vec_vld_o(vec_vld_o), .reg_wr_i(reg_wr_i),
      .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
   );

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] m_prev, m_irr, m_imr, m_isr, m_base, m_pend, m_vec;
   logic       m_mid, m_vld;

   function automatic logic [7:0] allow_f(input logic [7:0] s);
      logic [7:0] a;
      for (int i = 0; i < 8; i++) begin
         a[i] = 1'b1;
         for (int j = 0; j <= i; j++) if (s[j]) a[i] = 1'b0;
      end
      return a;
   endfunction

   function automatic int low_f(input logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return -1;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic [7:0] irq, input logic ack, input logic wr,
                      input logic [1:0] adr, input logic [7:0] wd, input string tag);
      int w, t;
      logic [7:0] rise, clr, eclr, nirr, nisr, exp_rd;
      logic exp_intr;
      irq_i = irq; ack_i = ack; reg_wr_i = wr; reg_addr_i = adr; reg_wdata_i = wd;
      w    = low_f(m_irr & ~m_imr & allow_f(m_isr));
      rise = irq & ~m_prev;
      clr  = (ack && !m_mid && w >= 0) ? (8'd1 << w) : 8'd0;
      eclr = 8'd0;
      if (wr && adr == 2'd2) begin
         if (wd[7]) eclr = 8'd1 << wd[2:0];
         else begin
            t = low_f(m_isr);
            if (t >= 0) eclr = 8'd1 << t;
         end
      end
      nirr  = ((m_irr & ~clr) | rise) & irq;
      nisr  = (m_isr & ~eclr) | clr;
      m_vld = 1'b0;
      if (ack && !m_mid) begin
         m_mid  = 1'b1;
         m_pend = (w >= 0) ? {m_base[7:3], 3'(w)} : {m_base[7:3], 3'b111};
      end else if (ack && m_mid) begin
         m_mid = 1'b0;
         m_vld = 1'b1;
         m_vec = m_pend;
      end
      if (wr && adr == 2'd1) m_imr = wd;
      if (wr && adr == 2'd3) m_base = {wd[7:3], 3'b000};
      m_prev = irq; m_irr = nirr; m_isr = nisr;
      @(posedge clk);
      #(CLK_PERIOD/4);
      exp_intr = (low_f(m_irr & ~m_imr & allow_f(m_isr)) >= 0) && !m_mid;
      case (adr)
         2'd0:    exp_rd = m_irr;
         2'd1:    exp_rd = m_imr;
         2'd2:    exp_rd = m_isr;
         default: exp_rd = m_base;
      endcase
      chk(intr_o === exp_intr, {tag, " intr"}, {7'd0, intr_o}, {7'd0, exp_intr});
      chk(vec_vld_o === m_vld, {tag, " vld"}, {7'd0, vec_vld_o}, {7'd0, m_vld});
      if (m_vld) chk(vec_o === m_vec, {tag, " vector"}, vec_o, m_vec);
      chk(reg_rdata_o === exp_rd, {tag, " rdata"}, reg_rdata_o, exp_rd);
      @(negedge clk);
      ack_i = 1'b0; reg_wr_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] rq;
      void'($urandom(32'd4321));
      rst_n = 1'b0; irq_i = '0; ack_i = 1'b0; reg_wr_i = 1'b0;
      reg_addr_i = 2'd0; reg_wdata_i = '0;
      m_prev = 0; m_irr = 0; m_imr = 0; m_isr = 0; m_base = 0;
      m_pend = 0; m_vec = 0; m_mid = 0; m_vld = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state on every readable register
      chk(intr_o === 1'b0, "R1 intr", {7'd0, intr_o}, 8'h00);
      chk(vec_vld_o === 1'b0, "R1 vld", {7'd0, vec_vld_o}, 8'h00);
      for (int a = 0; a < 4; a++) begin
         reg_addr_i = 2'(a);
         #1;
         chk(reg_rdata_o === 8'h00, "R1 rdata", reg_rdata_o, 8'h00);
      end
      @(negedge clk);
      // R2: edge latch, withdrawal clears
      cyc(8'h20, 0, 0, 2'd0, 8'h00, "R2");
      chk(reg_rdata_o === 8'h20, "R2 pending", reg_rdata_o, 8'h20);
      cyc(8'h00, 0, 0, 2'd0, 8'h00, "R2");
      // R3: mask gating
      cyc(8'h00, 0, 1, 2'd1, 8'h08, "R3");
      cyc(8'h08, 0, 0, 2'd0, 8'h00, "R3");
      chk(intr_o === 1'b0, "R3 masked", {7'd0, intr_o}, 8'h00);
      cyc(8'h08, 0, 1, 2'd1, 8'h00, "R3");
      cyc(8'h00, 0, 0, 2'd0, 8'h00, "R3");
      // R11: base write, write to address 0 ignored
      cyc(8'h00, 0, 1, 2'd3, 8'hA5, "R11");
      chk(reg_rdata_o === 8'hA0, "R11 base", reg_rdata_o, 8'hA0);
      cyc(8'h00, 0, 1, 2'd0, 8'hFF, "R11");
      // R4 / R5 / R6: two requests, lowest index wins
      cyc(8'h44, 0, 0, 2'd0, 8'h00, "R4");
      cyc(8'h44, 1, 0, 2'd2, 8'h00, "R5");
      chk(reg_rdata_o === 8'h04, "R5 in-service", reg_rdata_o, 8'h04);
      cyc(8'h44, 0, 0, 2'd0, 8'h00, "R5");
      cyc(8'h44, 1, 0, 2'd0, 8'h00, "R6");
      chk(vec_o === 8'hA2, "R6 vector", vec_o, 8'hA2);
      // R7: lower level held, higher level preempts
      chk(intr_o === 1'b0, "R7 lower held", {7'd0, intr_o}, 8'h00);
      cyc(8'h45, 0, 0, 2'd0, 8'h00, "R7");
      chk(intr_o === 1'b1, "R7 preempt", {7'd0, intr_o}, 8'h01);
      cyc(8'h45, 1, 0, 2'd0, 8'h00, "R7");
      cyc(8'h45, 1, 0, 2'd2, 8'h00, "R7");
      chk(vec_o === 8'hA0, "R7 vector", vec_o, 8'hA0);
      // R8: non-specific end-of-interrupt
      cyc(8'h45, 0, 1, 2'd2, 8'h00, "R8");
      chk(reg_rdata_o === 8'h04, "R8 in-service", reg_rdata_o, 8'h04);
      // R9: specific end-of-interrupt, then the held level wins
      cyc(8'h45, 0, 1, 2'd2, 8'h82, "R9");
      chk(intr_o === 1'b1, "R9 released", {7'd0, intr_o}, 8'h01);
      cyc(8'h45, 1, 0, 2'd0, 8'h00, "R9");
      cyc(8'h45, 1, 0, 2'd0, 8'h00, "R9");
      cyc(8'h45, 0, 1, 2'd2, 8'h86, "R9");
      // R10: withdrawn request gives spurious type
      cyc(8'h10, 0, 0, 2'd0, 8'h00, "R10");
      cyc(8'h00, 0, 0, 2'd0, 8'h00, "R10");
      cyc(8'h00, 1, 0, 2'd2, 8'h00, "R10");
      cyc(8'h00, 1, 0, 2'd2, 8'h00, "R10");
      chk(vec_o === 8'hA7, "R10 spurious", vec_o, 8'hA7);
      chk(reg_rdata_o === 8'h00, "R10 in-service", reg_rdata_o, 8'h00);
      // Random traffic against the model
      rq = 8'h00;
      for (int k = 0; k < 4000; k++) begin
         if ($urandom % 3 == 0) rq = rq ^ (8'd1 << ($urandom % 8));
         cyc(rq, ($urandom % 5) == 0, ($urandom % 7) == 0,
             2'($urandom % 4), 8'($urandom), "RAND");
      end
      finish_run();
   end
endmodule